// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit carries out a set-vector-length operation. It holds two architectural lengths: the maximum vector length, which bounds how many register-file elements a vector operation may overwrite, and the current vector length. Each operation carries a 2-bit mode, an immediate length, a 64-bit source operand and a flag that asks for the scalar result to be written back. Depending on the mode, the unit updates the maximum length, the current length or both. It then returns the new current length as the write-back value.

The central calculation is a double clamp: the new length is the smallest of the current length, the maximum length and the source operand. Either register can be changed while the other is kept. When only the maximum length is changed, the current length is cut down to fit under it. A separate special-register write port sets the current length directly, with no write-back. Decode, the register file and traps belong to neighbouring blocks.

Top module: `vlen_unit`

## Requirements
- R1: A synchronous reset sets the maximum length and the current length to 0 and holds `rt_we` low.
- R2: Mode 2'b00 sets both the maximum length and the current length to the immediate.
- R3: Mode 2'b01 sets the maximum length to the immediate and the current length to min(operand, immediate).
- R4: Mode 2'b10 sets the current length to min(min(current, maximum), operand) and leaves the maximum length unchanged.
- R5: Mode 2'b11 sets the maximum length to the immediate and the current length to min(current, immediate), so the current length is truncated and otherwise kept.
- R6: The 64-bit operand is compared at its full width. Any value above 64 acts as 64, so 64'h1_0000_0003 counts as 64 and not 3.
- R7: An immediate above 64 acts as 64, so the maximum length never exceeds 64.
- R8: When `op_valid` and `op_rt_en` are both high, `rt_we` is high on the following cycle and `rt_data` holds the new current length, zero-extended. Otherwise `rt_we` stays low.
- R9: A special-register write sets the current length to min(`spr_data`, maximum), leaves the maximum length unchanged and never raises `rt_we`.
- R10: If an operation and a special-register write arrive in the same cycle, the operation is carried out and the special-register write is dropped.
- R11: After every update, the current length is no greater than the maximum length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present this cycle |
| op_mode | input | 2 | Operation mode (00, 01, 10, 11 as in R2 to R5) |
| op_imm | input | 7 | Immediate length |
| op_ra | input | 64 | Source operand |
| op_rt_en | input | 1 | Request write-back of the new length |
| spr_we | input | 1 | Special-register write to the current length |
| spr_data | input | 7 | Value for the special-register write |
| rt_we | output | 1 | Write-back enable, one cycle after the operation |
| rt_data | output | 64 | Write-back value: the new current length |

## Verification
The two lengths can only be seen through write-back values. A mode 2'b10 operation with an all-ones operand returns the current length without changing it. A special-register write of 64 followed by that same operation returns the maximum length. A wrong register value therefore shows up in `rt_data` one cycle after the next operation that reads it. A wrong maximum length usually shows up only through a later clamp or a deliberate probe, so each scenario ends by probing both registers.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
    typedef enum logic [1:0] {
        MODE_BOTH_IMM = 2'b00,
        MODE_MAX_CLAMP = 2'b01,
        MODE_LEN_ONLY = 2'b10,
        MODE_MAX_TRUNC = 2'b11
    } vlen_mode_e;
endpackage

// File: rtl/vlen_min.sv
module vlen_min #(
    parameter int W = 7
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        y = (a < b) ? a : b;
    end
endmodule

// File: rtl/vlen_sat.sv
module vlen_sat #(
    parameter int IN_W    = 64,
    parameter int OUT_W   = 7,
    parameter int MAX_LEN = 64
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam logic [IN_W-1:0]  LIMIT_WIDE   = IN_W'(MAX_LEN);
    localparam logic [OUT_W-1:0] LIMIT_NARROW = OUT_W'(MAX_LEN);

    always_comb begin
        if (din > LIMIT_WIDE) begin
            dout = LIMIT_NARROW;
        end else begin
            dout = din[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/vlen_unit.sv
module vlen_unit #(
    parameter int XLEN    = 64,
    parameter int MAX_LEN = 64,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [1:0]       op_mode,
    input  logic [LEN_W-1:0] op_imm,
    input  logic [XLEN-1:0]  op_ra,
    input  logic             op_rt_en,
    input  logic             spr_we,
    input  logic [LEN_W-1:0] spr_data,
    output logic             rt_we,
    output logic [XLEN-1:0]  rt_data
);
    import vlen_pkg::*;

    typedef struct packed {
        logic [LEN_W-1:0] mvl;
        logic [LEN_W-1:0] vl;
        logic             rt_we;
        logic [XLEN-1:0]  rt_data;
    } state_t;

    state_t state_d, state_q;

    logic [LEN_W-1:0] ra_sat;
    logic [LEN_W-1:0] imm_sat;
    logic [LEN_W-1:0] vl_in_mvl;
    logic [LEN_W-1:0] len_clamp;
    logic [LEN_W-1:0] ra_vs_imm;
    logic [LEN_W-1:0] vl_vs_imm;
    logic [LEN_W-1:0] spr_clamp;

    vlen_sat #(.IN_W(XLEN), .OUT_W(LEN_W), .MAX_LEN(MAX_LEN)) u_ra_sat (
        .din(op_ra), .dout(ra_sat)
    );
    vlen_sat #(.IN_W(LEN_W), .OUT_W(LEN_W), .MAX_LEN(MAX_LEN)) u_imm_sat (
        .din(op_imm), .dout(imm_sat)
    );

    vlen_min #(.W(LEN_W)) u_min_cur (.a(state_q.vl), .b(state_q.mvl), .y(vl_in_mvl));
    vlen_min #(.W(LEN_W)) u_min_ra  (.a(vl_in_mvl),  .b(ra_sat),      .y(len_clamp));
    vlen_min #(.W(LEN_W)) u_min_ri  (.a(ra_sat),     .b(imm_sat),     .y(ra_vs_imm));
    vlen_min #(.W(LEN_W)) u_min_vi  (.a(state_q.vl), .b(imm_sat),     .y(vl_vs_imm));
    vlen_min #(.W(LEN_W)) u_min_spr (.a(spr_data),   .b(state_q.mvl), .y(spr_clamp));

    always_comb begin
        state_d         = state_q;
        state_d.rt_we   = 1'b0;
        if (op_valid) begin
            unique case (vlen_mode_e'(op_mode))
                MODE_BOTH_IMM: begin
                    state_d.mvl = imm_sat;
                    state_d.vl  = imm_sat;
                end
                MODE_MAX_CLAMP: begin
                    state_d.mvl = imm_sat;
                    state_d.vl  = ra_vs_imm;
                end
                MODE_LEN_ONLY: begin
                    state_d.vl  = len_clamp;
                end
                MODE_MAX_TRUNC: begin
                    state_d.mvl = imm_sat;
                    state_d.vl  = vl_vs_imm;
                end
                default: begin
                    state_d.vl  = state_q.vl;
                end
            endcase
            if (op_rt_en) begin
                state_d.rt_we   = 1'b1;
                state_d.rt_data = XLEN'(state_d.vl);
            end
        end else if (spr_we) begin
            state_d.vl = spr_clamp;
        end
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign rt_we   = state_q.rt_we;
    assign rt_data = state_q.rt_data;

    AST_VL_LE_MVL: assert property (@(posedge clk) disable iff (rst)
        state_q.vl <= state_q.mvl); // R11
    AST_MVL_CAP: assert property (@(posedge clk) disable iff (rst)
        state_q.mvl <= LEN_W'(MAX_LEN)); // R7
    AST_RT_CARRIES_VL: assert property (@(posedge clk) disable iff (rst)
        state_q.rt_we |-> (state_q.rt_data == XLEN'(state_q.vl))); // R8
    AST_RT_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && op_rt_en) |=> !rt_we); // R8
    AST_SPR_NO_RT: assert property (@(posedge clk) disable iff (rst)
        (spr_we && !op_valid) |=> !rt_we); // R9
    AST_LEN_ONLY_KEEPS_MVL: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_mode == 2'b10) |=> (state_q.mvl == $past(state_q.mvl))); // R4
    AST_SPR_KEEPS_MVL: assert property (@(posedge clk) disable iff (rst)
        (spr_we && !op_valid) |=> (state_q.mvl == $past(state_q.mvl))); // R9
endmodule

// File: tb/sim_vlen_unit.sv
module sim_vlen_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_mode;
    logic [6:0]  op_imm;
    logic [63:0] op_ra;
    logic        op_rt_en;
    logic        spr_we;
    logic [6:0]  spr_data;
    logic        rt_we;
    logic [63:0] rt_data;

    int checks = 0;
    int errors = 0;
    logic        g_we;
    logic [63:0] g_data;

    localparam logic [63:0] ALL_ONES = '1;

    vlen_unit u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_mode(op_mode),
        .op_imm(op_imm), .op_ra(op_ra), .op_rt_en(op_rt_en),
        .spr_we(spr_we), .spr_data(spr_data), .rt_we(rt_we), .rt_data(rt_data)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] m, input logic [6:0] imm,
                         input logic [63:0] ra, input logic rten);
        @(negedge clk);
        op_valid = 1'b1; op_mode = m; op_imm = imm; op_ra = ra; op_rt_en = rten;
        @(negedge clk);
        g_we = rt_we; g_data = rt_data;
        op_valid = 1'b0; op_rt_en = 1'b0;
    endtask

    task automatic spr_write(input logic [6:0] v);
        @(negedge clk);
        spr_we = 1'b1; spr_data = v;
        @(negedge clk);
        g_we = rt_we;
        spr_we = 1'b0;
    endtask

    task automatic probe_vl(input string req, input logic [63:0] exp);
        do_op(2'b10, 7'd0, ALL_ONES, 1'b1);
        check(req, {63'd0, g_we}, 64'd1);
        check(req, g_data, exp);
    endtask

    task automatic probe_mvl(input string req, input logic [63:0] exp);
        spr_write(7'd64);
        probe_vl(req, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 rt_we idle", {63'd0, rt_we}, 64'd0);
        probe_vl("R1 vl", 64'd0);
        probe_mvl("R1 mvl", 64'd0);
    endtask

    task automatic t_both_imm;
        do_op(2'b00, 7'd20, 64'd3, 1'b1);
        check("R2 rt", g_data, 64'd20);
        probe_mvl("R2 mvl", 64'd20);
    endtask

    task automatic t_max_clamp;
        do_op(2'b01, 7'd32, 64'd10, 1'b1);
        check("R3 ra smaller", g_data, 64'd10);
        probe_mvl("R3 mvl", 64'd32);
        do_op(2'b01, 7'd16, 64'd100, 1'b1);
        check("R3 imm smaller", g_data, 64'd16);
    endtask

    task automatic t_len_only;
        do_op(2'b00, 7'd40, 64'd0, 1'b0);
        do_op(2'b10, 7'd5, 64'd25, 1'b1);
        check("R4 clamp ra", g_data, 64'd25);
        do_op(2'b10, 7'd60, 64'd30, 1'b1);
        check("R4 clamp current", g_data, 64'd25);
        probe_mvl("R4 mvl kept", 64'd40);
    endtask

    task automatic t_max_trunc;
        do_op(2'b00, 7'd40, 64'd0, 1'b0);
        do_op(2'b11, 7'd12, 64'd0, 1'b1);
        check("R5 truncate", g_data, 64'd12);
        do_op(2'b11, 7'd50, 64'd0, 1'b1);
        check("R5 keep", g_data, 64'd12);
        probe_vl("R5 vl", 64'd12);
        probe_mvl("R5 mvl", 64'd50);
    endtask

    task automatic t_saturate;
        do_op(2'b00, 7'd64, 64'd0, 1'b0);
        do_op(2'b10, 7'd0, 64'h1_0000_0003, 1'b1);
        check("R6 wide ra", g_data, 64'd64);
        do_op(2'b01, 7'd50, 64'd65, 1'b1);
        check("R6 ra 65", g_data, 64'd50);
        do_op(2'b01, 7'd64, 64'h8000_0000_0000_0001, 1'b1);
        check("R6 top bit", g_data, 64'd64);
    endtask

    task automatic t_imm_cap;
        do_op(2'b00, 7'd100, 64'd0, 1'b1);
        check("R7 rt", g_data, 64'd64);
        probe_mvl("R7 mvl", 64'd64);
        do_op(2'b11, 7'd127, 64'd0, 1'b0);
        probe_mvl("R7 trunc mvl", 64'd64);
    endtask

    task automatic t_rt_enable;
        do_op(2'b00, 7'd30, 64'd0, 1'b0);
        check("R8 no rt", {63'd0, g_we}, 64'd0);
        probe_vl("R8 applied", 64'd30);
        @(negedge clk);
        check("R8 one pulse", {63'd0, rt_we}, 64'd0);
    endtask

    task automatic t_spr;
        do_op(2'b00, 7'd20, 64'd0, 1'b0);
        spr_write(7'd50);
        check("R9 no rt", {63'd0, g_we}, 64'd0);
        probe_vl("R9 clamped", 64'd20);
        spr_write(7'd5);
        probe_vl("R9 set", 64'd5);
        probe_mvl("R9 mvl kept", 64'd20);
    endtask

    task automatic t_priority;
        do_op(2'b00, 7'd40, 64'd0, 1'b0);
        @(negedge clk);
        spr_we = 1'b1; spr_data = 7'd7;
        op_valid = 1'b1; op_mode = 2'b00; op_imm = 7'd30; op_ra = 64'd0; op_rt_en = 1'b1;
        @(negedge clk);
        check("R10 rt", rt_data, 64'd30);
        spr_we = 1'b0; op_valid = 1'b0; op_rt_en = 1'b0;
        probe_vl("R10 vl", 64'd30);
    endtask

    task automatic t_invariant;
        do_op(2'b00, 7'd64, 64'd0, 1'b0);
        do_op(2'b11, 7'd3, 64'd0, 1'b0);
        spr_write(7'd64);
        probe_vl("R11 vl under mvl", 64'd3);
    endtask

    initial begin
        op_valid = 0; op_mode = 0; op_imm = 0; op_ra = 0; op_rt_en = 0;
        spr_we = 0; spr_data = 0; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_both_imm();
        t_max_clamp();
        t_len_only();
        t_max_trunc();
        t_saturate();
        t_imm_cap();
        t_rt_enable();
        t_spr();
        t_priority();
        t_invariant();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule